// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory that holds 1024 bytes. It samples the clock and data lines with a fast system clock, finds bus start and stop events, and takes in a device-select byte. When that byte matches, it acknowledges and then runs a write or a read. In a write it takes a word address byte and one or more data bytes. In a read it sends bytes for as long as the master keeps acknowledging them. The array is a synchronous register array inside the block. A single output enable pulls the open-drain data line low.

The select byte is sent most significant bit first. Its top four bits must be `1010`. Bit 3 must equal the `devStrap` input. Bits 2:1 pick one of four 256-byte blocks, and bit 0 selects a read (1) or a write (0). A write select stores the block bits as address bits 9:8, and the word address byte that follows gives bits 7:0. A read select that comes with no word address continues from the internal address register, which always points one past the last byte accessed. A repeated start begins a new select byte and keeps that register. This is how a random read is built: a write select, then a word address, then a repeated start with a read select.

Top module: `twi_mem_slave`

## Requirements
- R1: While reset is held and right after it is released, `sdaOe` is low.
- R2: The select byte is acknowledged (the data line pulled low during the ninth clock) only when bits 7:4 equal `1010` and bit 3 equals `devStrap`. Otherwise the block leaves the line released for that byte and for the rest of the transaction.
- R3: While `busy` is high, a matching select byte is not acknowledged.
- R4: In a write, the word address byte and every data byte are acknowledged. Each data byte is stored at the current address.
- R5: Select bits 2:1 of a write become address bits 9:8, so the same word address in two blocks refers to two separate bytes.
- R6: After each stored byte, address bits 3:0 wrap within their 16-byte group while bits 9:4 stay fixed. Four bytes written from word 0x0E land at 0x0E, 0x0F, 0x00 and 0x01.
- R7: A write select plus word address, followed by a repeated start and a read select, returns the byte at that address, with bit 7 first.
- R8: When the master drives the acknowledge bit low after a read byte, the next byte follows at the address plus one. The address counts through all ten bits, so 0x3FF is followed by 0x000.
- R9: A read select with no word address returns the byte one past the last byte accessed. The block bits of that select are ignored.
- R10: A high acknowledge bit after a read byte ends the transfer. The block stops driving, and later clocks read 0xFF. A stop returns it to idle with `sdaOe` low.
- R11: A start followed by a stop in the middle of a data byte cancels that byte, and the stored contents are unchanged.
- R12: `sdaOe` changes only after the synchronized clock falls, and never while the clock line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired-AND of all drivers) |
| devStrap | input | 1 | Value that select bit 3 must carry |
| busy | input | 1 | Write engine busy; suppresses the select acknowledge |
| sdaOe | output | 1 | Pull data line low when high |

## Verification
The bench acts as the bus master. It writes a page that runs past the end of its 16-byte group. A design that carried the increment into bit 4 would store the last two bytes at 0x10 and 0x11, and the read-back of word 0x00 would then return the wrong bytes. It reads across 0x3FF and then does a current read. Wrong carry logic, or a register that is not advanced on each load, shows up there as the wrong byte. It also checks a select with the wrong strap, a select with the wrong prefix, a select while busy, and a data byte cut short by a start and stop. A design that acknowledged the bad selects, or committed the partial byte, would pull the line low where it must stay high, or would change the stored value that is read back afterwards. A monitor counts every change of the data enable while the clock is high. Any such change means a false start or stop on a real bus.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEL,
    S_WADDR,
    S_WDATA,
    S_ACK,
    S_TX,
    S_TXACK,
    S_WAIT
  } ctrlState_t;

  typedef enum logic [1:0] {
    K_SEL,
    K_ADDR,
    K_DATA
  } ackKind_t;

  // Strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic shiftIn;
    logic shiftTx;
    logic loadTx;
    logic ackOn;
    logic oeOff;
    logic latchBlock;
    logic loadAddr;
    logic writeByte;
  } dpStrobe_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] dly;

  assign raw = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[STAGES-1:0], raw[g]};
    end
    assign lvl[g] = pipe[STAGES-1];
    assign dly[g] = pipe[STAGES];
  end

  logic sclNow, sclOld, sdaNow, sdaOld;
  assign sclNow = lvl[0];
  assign sclOld = dly[0];
  assign sdaNow = lvl[1];
  assign sdaOld = dly[1];

  assign sdaLvl   = sdaNow;
  assign sclRise  = sclNow & ~sclOld;
  assign sclFall  = ~sclNow & sclOld;
  assign startDet = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopDet  = sclNow & sclOld & ~sdaOld & sdaNow;

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [DW-1:0] wData,
  input  logic [AW-1:0] rAddr,
  output logic [DW-1:0] rData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wAddr] <= wData;
    rData <= cells[rAddr];
  end

endmodule

// File: rtl/twi_datapath.sv
module twi_datapath
  import twi_mem_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 10,
  parameter int PAGE_BYTES = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic          sdaLvl,
  output logic [DW-1:0] rxByte,
  output logic          sdaOe
);
  localparam int BLK_W   = AW - DW;
  localparam int BLK_LSB = 1;
  localparam int PB      = $clog2(PAGE_BYTES);

  logic [DW-1:0]    shiftReg;
  logic [AW-1:0]    addrReg;
  logic [BLK_W-1:0] blockReg;
  logic             oeReg;
  logic [DW-1:0]    rdData;

  twi_mem_array #(.DW(DW), .AW(AW)) u_array (
    .clk  (clk),
    .we   (strobe.writeByte),
    .wAddr(addrReg),
    .wData(shiftReg),
    .rAddr(addrReg),
    .rData(rdData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrReg  <= '0;
      blockReg <= '0;
      oeReg    <= 1'b0;
    end else begin
      if (strobe.shiftIn)      shiftReg <= {shiftReg[DW-2:0], sdaLvl};
      else if (strobe.loadTx)  shiftReg <= rdData;
      else if (strobe.shiftTx) shiftReg <= {shiftReg[DW-2:0], 1'b1};

      if (strobe.latchBlock) blockReg <= shiftReg[BLK_LSB +: BLK_W];

      if (strobe.loadAddr)       addrReg <= {blockReg, shiftReg};
      else if (strobe.writeByte) addrReg <= {addrReg[AW-1:PB], addrReg[PB-1:0] + 1'b1};
      else if (strobe.loadTx)    addrReg <= addrReg + 1'b1;

      if (strobe.loadTx)       oeReg <= ~rdData[DW-1];
      else if (strobe.shiftTx) oeReg <= ~shiftReg[DW-2];
      else if (strobe.ackOn)   oeReg <= 1'b1;
      else if (strobe.oeOff)   oeReg <= 1'b0;
    end
  end

  assign rxByte = shiftReg;
  assign sdaOe  = oeReg;

endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_mem_pkg::*;
#(
  parameter int         DW         = 8,
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaLvl,
  input  logic       busy,
  input  logic       devStrap,
  input  logic [4:0] selTag,
  input  logic       rwBit,
  output dpStrobe_t  strobe,
  output ctrlState_t state
);
  localparam int CNT_W = $clog2(DW + 1);

  ctrlState_t stateNx;
  ackKind_t   kind, kindNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic rdMode, rdNx;
  logic mAck, mAckNx;
  logic byteDone, selHit;

  assign byteDone = (cnt == CNT_W'(DW));
  assign selHit   = (selTag[4:1] == DEV_PREFIX) && (selTag[0] == devStrap) && !busy;

  always_comb begin
    stateNx = state;
    kindNx  = kind;
    cntNx   = cnt;
    rdNx    = rdMode;
    mAckNx  = mAck;
    strobe  = '0;
    if (startDet) begin
      stateNx      = S_SEL;
      cntNx        = '0;
      strobe.oeOff = 1'b1;
    end else if (stopDet) begin
      stateNx      = S_IDLE;
      cntNx        = '0;
      strobe.oeOff = 1'b1;
    end else begin
      case (state)
        S_SEL, S_WADDR, S_WDATA: begin
          if (sclRise && !byteDone) begin
            strobe.shiftIn = 1'b1;
            cntNx          = cnt + 1'b1;
          end else if (sclFall && byteDone) begin
            cntNx = '0;
            if (state == S_SEL) begin
              if (selHit) begin
                strobe.ackOn      = 1'b1;
                strobe.latchBlock = !rwBit;
                rdNx              = rwBit;
                kindNx            = K_SEL;
                stateNx           = S_ACK;
              end else begin
                stateNx = S_WAIT;
              end
            end else if (state == S_WADDR) begin
              strobe.loadAddr = 1'b1;
              strobe.ackOn    = 1'b1;
              kindNx          = K_ADDR;
              stateNx         = S_ACK;
            end else begin
              strobe.writeByte = 1'b1;
              strobe.ackOn     = 1'b1;
              kindNx           = K_DATA;
              stateNx          = S_ACK;
            end
          end
        end
        S_ACK: begin
          if (sclFall) begin
            cntNx = '0;
            if (kind == K_SEL && rdMode) begin
              strobe.loadTx = 1'b1;
              stateNx       = S_TX;
            end else begin
              strobe.oeOff = 1'b1;
              stateNx      = (kind == K_SEL) ? S_WADDR : S_WDATA;
            end
          end
        end
        S_TX: begin
          if (sclRise) begin
            cntNx = cnt + 1'b1;
          end else if (sclFall) begin
            if (byteDone) begin
              strobe.oeOff = 1'b1;
              cntNx        = '0;
              stateNx      = S_TXACK;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        S_TXACK: begin
          if (sclRise) begin
            mAckNx = sdaLvl;
          end else if (sclFall) begin
            if (!mAck) begin
              strobe.loadTx = 1'b1;
              cntNx         = '0;
              stateNx       = S_TX;
            end else begin
              stateNx = S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      kind   <= K_SEL;
      cnt    <= '0;
      rdMode <= 1'b0;
      mAck   <= 1'b1;
    end else begin
      state  <= stateNx;
      kind   <= kindNx;
      cnt    <= cntNx;
      rdMode <= rdNx;
      mAck   <= mAckNx;
    end
  end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int         DW          = 8,
  parameter int         AW          = 10,
  parameter int         PAGE_BYTES  = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic devStrap,
  input  logic busy,
  output logic sdaOe
);
  logic sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [DW-1:0] rxByte;
  dpStrobe_t  strobe;
  ctrlState_t ctrlState;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .sdaLvl  (sdaLvl),
    .sclRise (sclRise),
    .sclFall (sclFall),
    .startDet(startDet),
    .stopDet (stopDet)
  );

  twi_ctrl #(.DW(DW), .DEV_PREFIX(DEV_PREFIX)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclRise (sclRise),
    .sclFall (sclFall),
    .startDet(startDet),
    .stopDet (stopDet),
    .sdaLvl  (sdaLvl),
    .busy    (busy),
    .devStrap(devStrap),
    .selTag  (rxByte[DW-1:DW-5]),
    .rwBit   (rxByte[0]),
    .strobe  (strobe),
    .state   (ctrlState)
  );

  twi_datapath #(.DW(DW), .AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .sdaLvl(sdaLvl),
    .rxByte(rxByte),
    .sdaOe (sdaOe)
  );

endmodule

// File: rtl/twi_mem_checker.sv
module twi_mem_checker
  import twi_mem_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic       sclFall,
  input logic       startDet,
  input logic       stopDet,
  input logic       busy,
  input ctrlState_t ctrlState
);

  // R1
  a_r1_reset_released: assert property (@(posedge clk) $rose(rstN) |-> !sdaOe);

  // R2
  a_r2_unaddressed_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S_WAIT) |-> !sdaOe);

  // R3
  a_r3_busy_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S_SEL && busy) |=> !sdaOe);

  // R8
  a_r8_release_for_master_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S_TXACK) |-> !sdaOe);

  // R10
  a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (ctrlState == S_IDLE) && !sdaOe);

  // R12
  a_r12_oe_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> ($past(sclFall) || $past(startDet) || $past(stopDet)));

endmodule

bind twi_mem_slave twi_mem_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sdaOe    (sdaOe),
  .sclFall  (sclFall),
  .startDet (startDet),
  .stopDet  (stopDet),
  .busy     (busy),
  .ctrlState(ctrlState)
);

// File: tb/tb_twi_mem_slave.sv
`timescale 1ns/1ps
module tb_twi_mem_slave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic devStrap = 1'b1;
  logic busy = 1'b0;
  logic sdaOe;
  logic sdaBus;

  int chkCnt = 0;
  int errCnt = 0;
  int oeHighChg = 0;
  logic prevOe = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sdaBus = mSda & ~sdaOe;

  twi_mem_slave dut (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (mScl),
    .sdaIn   (sdaBus),
    .devStrap(devStrap),
    .busy    (busy),
    .sdaOe   (sdaOe)
  );

  // R12 monitor: data enable must not move while the clock line is high
  always @(negedge clk) begin
    if (rstN) begin
      if (mScl && (sdaOe !== prevOe)) oeHighChg++;
      prevOe = sdaOe;
    end
  end

  task automatic chk(string req, int act, int exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    waitClk(5); mSda = 1'b1; waitClk(10); mScl = 1'b1; waitClk(10);
    mSda = 1'b0; waitClk(10); mScl = 1'b0;
  endtask

  task automatic stopC();
    waitClk(5); mSda = 1'b0; waitClk(10); mScl = 1'b1; waitClk(10);
    mSda = 1'b1; waitClk(10);
  endtask

  task automatic bitOut(logic b);
    waitClk(5); mSda = b; waitClk(10); mScl = 1'b1; waitClk(20); mScl = 1'b0;
  endtask

  task automatic bitIn(output logic v);
    waitClk(5); mSda = 1'b1; waitClk(10); mScl = 1'b1; waitClk(10);
    v = sdaBus; waitClk(10); mScl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
    bitIn(v);
    acked = !v;
  endtask

  task automatic readByte(input logic nack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bitIn(v);
      b[i] = v;
    end
    bitOut(nack);
  endtask

  function automatic logic [7:0] sel(logic [3:0] pre, logic strap, logic [1:0] blk, logic rd);
    return {pre, strap, blk, rd};
  endfunction

  task automatic writeBytes(string req, logic [1:0] blk, logic [7:0] wa,
                            input logic [7:0] d [4], int n);
    logic a;
    startC();
    sendByte(sel(4'b1010, 1'b1, blk, 1'b0), a); chk({req, " select ack"}, a, 1);
    sendByte(wa, a); chk({req, " R4 word address ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], a); chk({req, " R4 data ack"}, a, 1);
    end
    stopC();
  endtask

  task automatic readAt(string req, logic [1:0] blk, logic [7:0] wa,
                        input logic [7:0] e [4], int n);
    logic a;
    logic [7:0] b;
    startC();
    sendByte(sel(4'b1010, 1'b1, blk, 1'b0), a); chk({req, " R7 select ack"}, a, 1);
    sendByte(wa, a); chk({req, " R7 word address ack"}, a, 1);
    startC();
    sendByte(sel(4'b1010, 1'b1, blk, 1'b1), a); chk({req, " R7 read select ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      readByte(i == n - 1, b);
      chk({req, " read data"}, b, e[i]);
    end
    stopC();
  endtask

  task automatic t_reset();
    chk("R1 enable low after reset", sdaOe, 0);
  endtask

  task automatic t_basicWrite();
    writeBytes("R4", 2'd1, 8'h34, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1);
    readAt("R7", 2'd1, 8'h34, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1);
  endtask

  task automatic t_blocks();
    writeBytes("R5", 2'd2, 8'h34, '{8'h3C, 8'h00, 8'h00, 8'h00}, 1);
    readAt("R5 block 1", 2'd1, 8'h34, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1);
    readAt("R5 block 2", 2'd2, 8'h34, '{8'h3C, 8'h00, 8'h00, 8'h00}, 1);
  endtask

  task automatic t_pageWrap();
    writeBytes("R6", 2'd0, 8'h0E, '{8'h11, 8'h22, 8'h33, 8'h44}, 4);
    readAt("R6 top of group", 2'd0, 8'h0E, '{8'h11, 8'h22, 8'h00, 8'h00}, 2);
    readAt("R6 wrapped to group start", 2'd0, 8'h00, '{8'h33, 8'h44, 8'h00, 8'h00}, 2);
  endtask

  task automatic t_seqWrap();
    writeBytes("R8", 2'd3, 8'hFF, '{8'h77, 8'h00, 8'h00, 8'h00}, 1);
    readAt("R8 sequential across 0x3FF", 2'd3, 8'hFF, '{8'h77, 8'h33, 8'h00, 8'h00}, 2);
  endtask

  task automatic t_current();
    logic a;
    logic [7:0] b;
    startC();
    sendByte(sel(4'b1010, 1'b1, 2'd3, 1'b1), a); chk("R9 current read select ack", a, 1);
    readByte(1'b1, b); chk("R9 current read data", b, 8'h44);
    readByte(1'b1, b); chk("R10 quiet after master nack", b, 8'hFF);
    stopC();
    chk("R10 enable low after stop", sdaOe, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    logic [7:0] b;
    startC();
    sendByte(sel(4'b1010, 1'b0, 2'd0, 1'b1), a); chk("R2 strap mismatch no ack", a, 0);
    readByte(1'b1, b); chk("R2 strap mismatch quiet", b, 8'hFF);
    stopC();
    startC();
    sendByte(sel(4'b1011, 1'b1, 2'd0, 1'b0), a); chk("R2 prefix mismatch no ack", a, 0);
    stopC();
    startC();
    sendByte(sel(4'b1010, 1'b1, 2'd0, 1'b0), a); chk("R2 matching select ack", a, 1);
    stopC();
  endtask

  task automatic t_busy();
    logic a;
    busy = 1'b1;
    startC();
    sendByte(sel(4'b1010, 1'b1, 2'd0, 1'b0), a); chk("R3 busy suppresses ack", a, 0);
    stopC();
    busy = 1'b0;
    startC();
    sendByte(sel(4'b1010, 1'b1, 2'd0, 1'b0), a); chk("R3 ack once idle", a, 1);
    stopC();
  endtask

  task automatic t_cancel();
    logic a;
    startC();
    sendByte(sel(4'b1010, 1'b1, 2'd1, 1'b0), a); chk("R11 select ack", a, 1);
    sendByte(8'h34, a); chk("R11 word address ack", a, 1);
    for (int i = 0; i < 4; i++) bitOut(1'b0);
    startC();
    stopC();
    chk("R11 enable low after cancel", sdaOe, 0);
    readAt("R11 byte unchanged", 2'd1, 8'h34, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", chkCnt, errCnt);
      $finish;
    end
  end

  initial begin
    waitClk(4);
    chk("R1 enable low in reset", sdaOe, 0);
    rstN = 1'b1;
    waitClk(4);
    t_reset();
    mScl = 1'b1;
    t_basicWrite();
    t_blocks();
    t_pageWrap();
    t_seqWrap();
    t_current();
    t_mismatch();
    t_busy();
    t_cancel();
    chk("R12 enable changes while clock high", oeHighChg, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", chkCnt, errCnt);
    $finish;
  end

endmodule